// File: doc/BRIEF.md
# ATA Host Controller Register File

This block is the register file of a simple ATA host adapter, attached to a 32-bit processor bus. It holds the control word, a status word, the timing words for programmed I/O and DMA transfers, and a transmit buffer. It also exposes a receive word that the data path supplies. The control word drives the hardware-reset line of the attached drives and the controller-enable signal. The status word carries a sticky interrupt flag together with read-only identification fields. A drive-side interrupt request sets that flag, and the flag drives a level interrupt output.

A feature-level parameter (1, 2 or 3) decides which registers can be seen. The two per-drive fast PIO timing words read back only at level 2 and above. The DMA timing words and the receive word read back only at level 3. Host registers lie in the lower half of a 128-byte window, where address bit 6 is 0. In the upper half, the block only watches for writes to the drive/head register so that it can latch which drive is selected. The drive-side protocol itself lives elsewhere.

Top module: `ata_host_regs`

## Requirements
- R1: After reset, the control word reads 0x00000001 at offset 0x00. dev_reset is 1, ctrl_enable is 0, irq_o is 0, dev_sel is 0 and ack is 0.
- R2: The status word at 0x04 resets with the feature level in bits 31:28 and the revision parameter modulo 16 in bits 27:24. All other bits are 0, and bit 0 is the interrupt flag.
- R3: The PIO timing word (0x08) and both fast timing words (0x0C drive 0, 0x10 drive 1) reset to 0x17021C06. The fields are end-of-cycle 31:24 = 23, t4 23:16 = 2, t2 15:8 = 28 and t1 7:0 = 6.
- R4: Both DMA timing words (0x14, 0x18) reset to 0x15001504, which is end-of-cycle 31:24 = 21, Td 15:8 = 21 and Tm 7:0 = 4. The transmit buffer resets to 0, is written at 0x1C and is driven on tx_data.
- R5: A write to 0x00 stores the whole word. dev_reset follows bit 0 and ctrl_enable follows bit 1 from the next cycle on. Without such a write, dev_reset holds.
- R6: If the flag is clear when dev_irq is sampled high, the flag sets and irq_o is 1 from the next cycle. A request that arrives while the flag is already set changes nothing.
- R7: A status write with bit 0 = 0 clears a set flag and drops irq_o on the next cycle. A status write with bit 0 = 1 changes nothing, and no other status bit is writable.
- R8: The fast timing words read 0 unless the feature level is above 1. The DMA words, and the receive word at 0x1C (rx_data), read 0 unless the level is above 2. Writes to these words are still stored.
- R9: Host offsets 0x20 to 0x3C, and any address whose low two bits are nonzero, read 0 and ignore writes.
- R10: A feature-level parameter outside 1..3 behaves as level 1.
- R11: Every request is acknowledged by ack high for exactly one cycle, two clock edges after the edge that samples it. The read data reflects the state at the sampling edge.
- R12: While ctrl_enable is 1, a write to the drive/head address 0x58 loads dev_sel from data bit 4. Any other upper-half write leaves dev_sel unchanged, and so does any write while ctrl_enable is 0. Upper-half reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Single-cycle bus request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address within the window |
| wdata | input | 32 | Write data |
| dev_irq | input | 1 | Interrupt request from the drive side |
| rx_data | input | 32 | Receive word from the data path |
| rdata | output | 32 | Read data, valid with ack |
| ack | output | 1 | Access acknowledge |
| irq_o | output | 1 | Level interrupt |
| dev_reset | output | 1 | Drive hardware reset |
| ctrl_enable | output | 1 | Controller enable |
| dev_sel | output | 1 | Selected drive |
| tx_data | output | 32 | Transmit buffer contents |

## Verification
A bus read issued in cycle c is acknowledged with its data in cycle c+2. The driver stamps each queued item with that due cycle, and the monitor rejects any ack that arrives earlier or later. Side effects of a write or of an interrupt request take effect at the sampling edge. The bench therefore checks dev_reset, ctrl_enable, dev_sel and irq_o at the falling edge one cycle after the stimulus, and reads state back only through later bus reads. A second instance with an out-of-range feature level shares the bus and is compared on every read.

// File: rtl/ahr_pkg.sv
package ahr_pkg;
    localparam int WORD_W  = 32;
    localparam int BANK_N  = 6;   // PIO, fast0, fast1, dma0, dma1, tx buffer
    localparam int VIS_N   = 5;   // bank words readable at their own offset

    typedef enum logic [3:0] {
        W_CTRL  = 4'd0,
        W_STAT  = 4'd1,
        W_PIO   = 4'd2,
        W_FAST0 = 4'd3,
        W_FAST1 = 4'd4,
        W_DMA0  = 4'd5,
        W_DMA1  = 4'd6,
        W_BUF   = 4'd7
    } host_word_e;

    localparam logic [3:0] DEV_HEAD_WORD = 4'd6;  // 0x58 in the drive half
    localparam int         DEV_SEL_BIT   = 4;
    localparam int         RST_BIT       = 0;
    localparam int         EN_BIT        = 1;
    localparam int         IRQ_BIT       = 0;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic              dev_sel;
    } core_state_t;

    typedef struct packed {
        logic              v1;
        logic [WORD_W-1:0] d1;
        logic              ack;
        logic [WORD_W-1:0] rdata;
    } pipe_state_t;

    function automatic logic [WORD_W-1:0] pack_bytes(input int b3, input int b2,
                                                     input int b1, input int b0);
        logic [7:0] x3, x2, x1, x0;
        x3 = 8'(b3);
        x2 = 8'(b2);
        x1 = 8'(b1);
        x0 = 8'(b0);
        return {x3, x2, x1, x0};
    endfunction

    // Lowest feature level at which bank word i reads back.
    function automatic int min_level(input int i);
        if (i == 0)      return 1;
        else if (i <= 2) return 2;
        else             return 3;
    endfunction
endpackage

// File: rtl/ahr_timing_bank.sv
module ahr_timing_bank
    import ahr_pkg::*;
#(
    parameter int                          N    = BANK_N,
    parameter logic [N-1:0][WORD_W-1:0]    INIT = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N-1:0]                wr_en,
    input  logic [WORD_W-1:0]           wdata,
    output logic [N-1:0][WORD_W-1:0]    q
);
    logic [N-1:0][WORD_W-1:0] bank_d, bank_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            bank_d[i] = wr_en[i] ? wdata : bank_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= INIT;
        else        bank_q <= bank_d;
    end

    assign q = bank_q;
endmodule

// File: rtl/ahr_irq_flag.sv
module ahr_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (flag_q && clr_req)       flag_d = 1'b0;
        else if (!flag_q && set_req) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/ahr_bus_pipe.sv
module ahr_bus_pipe
    import ahr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WORD_W-1:0] rd_now,
    output logic              ack,
    output logic [WORD_W-1:0] rdata
);
    pipe_state_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.v1    = req;
        p_d.d1    = req ? rd_now : '0;
        p_d.ack   = p_q.v1;
        p_d.rdata = p_q.v1 ? p_q.d1 : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign ack   = p_q.ack;
    assign rdata = p_q.rdata;
endmodule

// File: rtl/ata_host_regs.sv
module ata_host_regs
    import ahr_pkg::*;
#(
    parameter int FEATURE_LEVEL = 3,
    parameter int REVISION      = 0,
    parameter int PIO_EOC       = 23,
    parameter int PIO_T4        = 2,
    parameter int PIO_T2        = 28,
    parameter int PIO_T1        = 6,
    parameter int DMA_EOC       = 21,
    parameter int DMA_TD        = 21,
    parameter int DMA_TM        = 4,
    parameter int ADDR_W        = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              dev_irq,
    input  logic [31:0]       rx_data,
    output logic [31:0]       rdata,
    output logic              ack,
    output logic              irq_o,
    output logic              dev_reset,
    output logic              ctrl_enable,
    output logic              dev_sel,
    output logic [31:0]       tx_data
);
    localparam int LEVEL = (FEATURE_LEVEL < 1 || FEATURE_LEVEL > 3) ? 1 : FEATURE_LEVEL;
    localparam logic [3:0] LEVEL4 = 4'(LEVEL);
    localparam logic [3:0] REV4   = 4'(REVISION & 15);
    localparam logic [WORD_W-1:0] PIO_INIT = pack_bytes(PIO_EOC, PIO_T4, PIO_T2, PIO_T1);
    localparam logic [WORD_W-1:0] DMA_INIT = pack_bytes(DMA_EOC, 0, DMA_TD, DMA_TM);
    localparam logic [BANK_N-1:0][WORD_W-1:0] BANK_INIT =
        {{WORD_W{1'b0}}, DMA_INIT, DMA_INIT, PIO_INIT, PIO_INIT, PIO_INIT};
    localparam int HOST_BIT = 6;

    // Address decode
    logic       aligned, host_sel, host_wr, clr_wr;
    logic [3:0] word;
    assign aligned  = (addr[1:0] == 2'b00);
    assign host_sel = !addr[HOST_BIT];
    assign word     = addr[5:2];
    assign host_wr  = req && we && host_sel && aligned;
    assign clr_wr   = host_wr && (word == W_STAT) && !wdata[IRQ_BIT];

    // Timing words and transmit buffer
    logic [BANK_N-1:0]              bank_we;
    logic [BANK_N-1:0][WORD_W-1:0]  bank_q;
    logic [VIS_N-1:0][WORD_W-1:0]   bank_vis;

    always_comb begin
        for (int i = 0; i < BANK_N; i++) begin
            bank_we[i] = host_wr && (word == 4'(i + 2));
        end
    end

    ahr_timing_bank #(.N(BANK_N), .INIT(BANK_INIT)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bank_we),
        .wdata (wdata),
        .q     (bank_q)
    );

    for (genvar g = 0; g < VIS_N; g++) begin : g_vis
        if (LEVEL >= min_level(g)) begin : g_on
            assign bank_vis[g] = bank_q[g];
        end else begin : g_off
            assign bank_vis[g] = '0;
        end
    end

    logic [WORD_W-1:0] rx_vis;
    if (LEVEL > 2) begin : g_rx_on
        assign rx_vis = rx_data;
    end else begin : g_rx_off
        assign rx_vis = '0;
    end

    // Interrupt flag
    logic flag;
    ahr_irq_flag u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (dev_irq),
        .clr_req (clr_wr),
        .flag    (flag)
    );

    // Control word and drive select
    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (host_wr && word == W_CTRL) begin
            st_d.ctrl = wdata;
        end
        if (req && we && !host_sel && aligned && st_q.ctrl[EN_BIT]
            && word == DEV_HEAD_WORD) begin
            st_d.dev_sel = wdata[DEV_SEL_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl    <= 32'h0000_0001;
            st_q.dev_sel <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read mux
    logic [WORD_W-1:0] rd_now;
    always_comb begin
        rd_now = '0;
        if (host_sel && aligned) begin
            case (word)
                W_CTRL:  rd_now = st_q.ctrl;
                W_STAT:  rd_now = {LEVEL4, REV4, 23'b0, flag};
                W_PIO:   rd_now = bank_vis[0];
                W_FAST0: rd_now = bank_vis[1];
                W_FAST1: rd_now = bank_vis[2];
                W_DMA0:  rd_now = bank_vis[3];
                W_DMA1:  rd_now = bank_vis[4];
                W_BUF:   rd_now = rx_vis;
                default: rd_now = '0;
            endcase
        end
    end

    ahr_bus_pipe u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .rd_now (rd_now),
        .ack    (ack),
        .rdata  (rdata)
    );

    assign irq_o       = flag;
    assign dev_reset   = st_q.ctrl[RST_BIT];
    assign ctrl_enable = st_q.ctrl[EN_BIT];
    assign dev_sel     = st_q.dev_sel;
    assign tx_data     = bank_q[BANK_N-1];
endmodule

// File: rtl/ahr_checker.sv
module ahr_checker #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              dev_irq,
    input logic              ack,
    input logic              irq_o,
    input logic              dev_reset
);
    logic stat_wr, stat_clr, ctrl_wr;
    assign stat_wr  = req && we && (addr == ADDR_W'(7'h04));
    assign stat_clr = stat_wr && !wdata[0];
    assign ctrl_wr  = req && we && (addr == ADDR_W'(7'h00));

    assert_ack_due_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ##2 ack);
    assert_ack_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req, 2));
    assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_irq && !irq_o) |=> irq_o);
    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !stat_clr) |=> irq_o);
    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && stat_clr) |=> !irq_o);
    assert_rst_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (dev_reset == $past(wdata[0])));
    assert_rst_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(dev_reset));
endmodule

bind ata_host_regs ahr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .dev_irq   (dev_irq),
    .ack       (ack),
    .irq_o     (irq_o),
    .dev_reset (dev_reset)
);

// File: tb/ata_host_regs_test.sv
`timescale 1ns/1ps
module ata_host_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, dev_irq = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0, rx_data = 32'hA5A5_0001;
    logic [31:0] rdata, tx_data, rdata_lo, tx_lo;
    logic        ack, irq_o, dev_reset, ctrl_enable, dev_sel;
    logic        ack_lo, irq_lo, rst_lo, en_lo, sel_lo;

    always #2 clk = ~clk;

    ata_host_regs #(.FEATURE_LEVEL(3), .REVISION(18)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .dev_irq(dev_irq), .rx_data(rx_data), .rdata(rdata), .ack(ack), .irq_o(irq_o),
        .dev_reset(dev_reset), .ctrl_enable(ctrl_enable), .dev_sel(dev_sel), .tx_data(tx_data));

    ata_host_regs #(.FEATURE_LEVEL(7), .REVISION(5)) uut_lo (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .dev_irq(dev_irq), .rx_data(rx_data), .rdata(rdata_lo), .ack(ack_lo), .irq_o(irq_lo),
        .dev_reset(rst_lo), .ctrl_enable(en_lo), .dev_sel(sel_lo), .tx_data(tx_lo));

    typedef struct {
        int          due;
        bit          cmp;
        logic [31:0] exp;
        logic [31:0] exp_lo;
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        req = 1'b0; we = 1'b0; dev_irq = 1'b0;
    endtask

    task automatic issue(input bit w, input logic [6:0] a, input logic [31:0] d,
                         input bit cmp, input logic [31:0] e, input logic [31:0] e_lo,
                         input string tag);
        item_t it;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; dev_irq = 1'b0;
        it.due = cyc + 2; it.cmp = cmp; it.exp = e; it.exp_lo = e_lo; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d, input string tag);
        issue(1'b1, a, d, 1'b0, '0, '0, tag);
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] e, input logic [31:0] e_lo,
                      input string tag);
        issue(1'b0, a, '0, 1'b1, e, e_lo, tag);
    endtask

    // Monitor: pops expected items as acknowledgements appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (ack !== ack_lo) check(1'b0, "R10 ack mismatch", 32'(ack_lo), 32'(ack));
                if (ack === 1'b1) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R11 unexpected ack", 32'd1, 32'd0);
                    end else begin
                        item_t it;
                        it = q.pop_front();
                        check(cyc == it.due, {it.tag, " R11 latency"}, 32'(cyc), 32'(it.due));
                        if (it.cmp) begin
                            check(rdata === it.exp, it.tag, rdata, it.exp);
                            check(rdata_lo === it.exp_lo, {it.tag, " lo"}, rdata_lo, it.exp_lo);
                        end
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [31:0] PIO_DEF = 32'h1702_1C06;
    localparam logic [31:0] DMA_DEF = 32'h1500_1504;
    localparam logic [31:0] ST_HI   = 32'h3200_0000;
    localparam logic [31:0] ST_LO   = 32'h1500_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state at the ports
        check(dev_reset === 1'b1, "R1 dev_reset", 32'(dev_reset), 32'd1);
        check(ctrl_enable === 1'b0, "R1 ctrl_enable", 32'(ctrl_enable), 32'd0);
        check(irq_o === 1'b0, "R1 irq_o", 32'(irq_o), 32'd0);
        check(dev_sel === 1'b0, "R1 dev_sel", 32'(dev_sel), 32'd0);
        check(ack === 1'b0, "R1 ack", 32'(ack), 32'd0);
        check(tx_data === 32'h0, "R4 tx reset", tx_data, 32'h0);

        rd(7'h00, 32'h1, 32'h1, "R1 ctrl reset");
        rd(7'h04, ST_HI, ST_LO, "R2 R10 status reset");
        rd(7'h08, PIO_DEF, PIO_DEF, "R3 pio reset");
        rd(7'h0C, PIO_DEF, 32'h0, "R3 R8 fast0 reset");
        rd(7'h10, PIO_DEF, 32'h0, "R3 R8 fast1 reset");
        rd(7'h14, DMA_DEF, 32'h0, "R4 R8 dma0 reset");
        rd(7'h18, DMA_DEF, 32'h0, "R4 R8 dma1 reset");
        rd(7'h1C, 32'hA5A5_0001, 32'h0, "R8 rx word");

        // R5 control word
        wr(7'h00, 32'h0000_0002, "R5 ctrl write");
        step();
        check(dev_reset === 1'b0, "R5 reset released", 32'(dev_reset), 32'd0);
        check(ctrl_enable === 1'b1, "R5 enable set", 32'(ctrl_enable), 32'd1);
        rd(7'h00, 32'h2, 32'h2, "R5 ctrl readback");
        wr(7'h00, 32'hF0F0_0003, "R5 ctrl write 3");
        step();
        check(dev_reset === 1'b1, "R5 reset asserted", 32'(dev_reset), 32'd1);
        rd(7'h00, 32'hF0F0_0003, 32'hF0F0_0003, "R5 full word stored");
        wr(7'h00, 32'h0000_0002, "R5 ctrl write 2");

        // R12 drive select
        wr(7'h58, 32'h0000_0010, "R12 head write");
        step();
        check(dev_sel === 1'b1, "R12 dev_sel set", 32'(dev_sel), 32'd1);
        wr(7'h5C, 32'h0000_0000, "R12 other drive reg");
        step();
        check(dev_sel === 1'b1, "R12 other addr ignored", 32'(dev_sel), 32'd1);
        wr(7'h00, 32'h0000_0000, "R12 disable");
        wr(7'h58, 32'h0000_0000, "R12 head write disabled");
        step();
        check(dev_sel === 1'b1, "R12 disabled ignored", 32'(dev_sel), 32'd1);
        wr(7'h00, 32'h0000_0002, "R12 enable");
        wr(7'h58, 32'h0000_0000, "R12 head write clear");
        step();
        check(dev_sel === 1'b0, "R12 dev_sel cleared", 32'(dev_sel), 32'd0);
        rd(7'h40, 32'h0, 32'h0, "R12 drive half read");

        // R6 / R7 interrupt flag
        @(negedge clk); req = 1'b0; dev_irq = 1'b1;
        step();
        check(irq_o === 1'b1, "R6 irq set", 32'(irq_o), 32'd1);
        rd(7'h04, ST_HI | 32'h1, ST_LO | 32'h1, "R6 status flag");
        @(negedge clk); req = 1'b0; dev_irq = 1'b1;
        step();
        check(irq_o === 1'b1, "R6 second request", 32'(irq_o), 32'd1);
        wr(7'h04, 32'hFFFF_FFFF, "R7 write one");
        step();
        check(irq_o === 1'b1, "R7 write one keeps", 32'(irq_o), 32'd1);
        rd(7'h04, ST_HI | 32'h1, ST_LO | 32'h1, "R7 status not writable");
        wr(7'h04, 32'h0, "R7 clear");
        step();
        check(irq_o === 1'b0, "R7 irq cleared", 32'(irq_o), 32'd0);
        rd(7'h04, ST_HI, ST_LO, "R7 status after clear");
        wr(7'h04, 32'h0, "R6 clear while clear");
        dev_irq = 1'b1;
        step();
        check(irq_o === 1'b1, "R6 set beside idle clear", 32'(irq_o), 32'd1);
        wr(7'h04, 32'h0, "R7 clear again");
        step();
        check(irq_o === 1'b0, "R7 cleared again", 32'(irq_o), 32'd0);

        // R8 gated words still store; R4 transmit buffer
        wr(7'h0C, 32'hDEAD_BEEF, "R8 fast0 write");
        rd(7'h0C, 32'hDEAD_BEEF, 32'h0, "R8 fast0 readback");
        wr(7'h18, 32'h0102_0304, "R8 dma1 write");
        rd(7'h18, 32'h0102_0304, 32'h0, "R8 dma1 readback");
        wr(7'h1C, 32'h1234_5678, "R4 tx write");
        step();
        check(tx_data === 32'h1234_5678, "R4 tx_data", tx_data, 32'h1234_5678);
        check(tx_lo === 32'h1234_5678, "R4 tx_data lo", tx_lo, 32'h1234_5678);

        // R9 unknown and misaligned addresses
        wr(7'h24, 32'hFFFF_FFFF, "R9 unknown write");
        wr(7'h09, 32'h0000_0000, "R9 misaligned write");
        rd(7'h24, 32'h0, 32'h0, "R9 unknown read");
        rd(7'h3C, 32'h0, 32'h0, "R9 top read");
        rd(7'h09, 32'h0, 32'h0, "R9 misaligned read");
        rd(7'h08, PIO_DEF, PIO_DEF, "R9 pio untouched");

        // R11 back-to-back write then read
        wr(7'h08, 32'h0A0B_0C0D, "R11 pio write");
        rd(7'h08, 32'h0A0B_0C0D, 32'h0A0B_0C0D, "R11 read after write");
        rd(7'h14, DMA_DEF, 32'h0, "R11 back-to-back");

        repeat (5) step();
        check(q.size() == 0, "R11 missing acks", 32'(q.size()), 32'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule